// File: doc/BRIEF.md
# Pipelined CORDIC Complex Rotator

This block multiplies a stream of 16-bit complex samples by a unit phasor whose angle is supplied with each sample. Each accepted sample leaves the block a fixed number of cycles later, rotated counterclockwise by the requested angle. A new sample may enter on every clock.

The angle is an unsigned binary fraction of one full turn. Legal codes cover the lower three quarters of the code space, which is the span from zero up to, but not including, three quarter turns. An entry stage folds the angle before any micro-rotation happens. Angles in the second quarter lose a quarter turn and the input is turned by +90 degrees to make up for it. Angles in the third quarter lose a half turn and both input components are negated. The residual is therefore never more than a quarter turn, and the chain of shift-and-add micro-rotations converges over that range. Each micro-rotation stage has its own arctangent constant, worked out at elaboration, so no table memory is needed. A constant shift-add multiplier at the output removes the accumulated rotation gain. It then rounds and saturates the result back to the sample width.

Top module: `cordic_rotator`

## Requirements
- R1: With `inValid` high and angle code `a` (ANG_W bits), the output is (inRe + j·inIm)·e^(j·2π·a/2^ANG_W), rounded to integers, within 5 LSB per component, for every legal `a` < 3·2^(ANG_W-2). Codes whose two top bits are `11` are illegal.
- R2: Codes with top bits `00` (first quarter) are rotated directly by the code's angle.
- R3: Codes with top bits `01` (second quarter) give the same accuracy, including at the boundary codes 2^(ANG_W-2)-1 and 2^(ANG_W-2).
- R4: Codes with top bits `10` (third quarter) give the same accuracy, including at 2^(ANG_W-1) and the highest legal code.
- R5: A sample is accepted on every clock, and its result appears exactly ITER+2 cycles (18 by default) after the edge that captured it.
- R6: `outValid` is high once for each accepted sample, in the same order, with idle gaps in the input reproduced in the output. No other output cycle is valid.
- R7: The rotation gain is compensated, so the output magnitude matches the input magnitude within the R1 tolerance.
- R8: A result outside the signed DATA_W range is clamped to +2^(DATA_W-1)-1 or -2^(DATA_W-1).
- R9: While `outValid` is low, `outRe` and `outIm` keep their previous values.
- R10: During reset and right after it, `outValid`, `outRe` and `outIm` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Qualifies the input sample and angle |
| inRe | input | DATA_W (16) | Real part of the input, two's complement |
| inIm | input | DATA_W (16) | Imaginary part of the input, two's complement |
| inAngle | input | ANG_W (16) | Rotation angle as an unsigned fraction of a full turn |
| outValid | output | 1 | Qualifies the rotated output |
| outRe | output | DATA_W (16) | Real part of the rotated sample |
| outIm | output | DATA_W (16) | Imaginary part of the rotated sample |

## Verification
The assertions check the following on every cycle:
- An accepted angle never lies in the illegal top quarter.
- The residual angle left after the last micro-rotation is within the final stage's arctangent plus rounding slack, which shows the fold and the stage directions kept the iteration convergent.
- The outputs stay still when nothing is emitted.
- No valid output appears unless an input was accepted within the pipeline depth.

The numerical accuracy of the rotation needs the bench's sweeps, because only they compare against an independently computed reference. The same holds for the seams between the three angle ranges, the saturation at full-scale corners, the exact latency and the preservation of bubbles. The sweeps cover several thousand angle codes on input vectors that include full-scale and diagonal corners.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Angle range selected by the two top bits of the angle code
  typedef enum logic [1:0] {
    RANGE_DIRECT  = 2'b00,
    RANGE_QUARTER = 2'b01,
    RANGE_HALF    = 2'b10,
    RANGE_ILLEGAL = 2'b11
  } angleRange_e;

  // Strobes from the control to the datapath edges
  typedef struct packed {
    logic loadPre;   // capture and fold a new sample
    logic loadOut;   // scale and register a finished sample
  } cordicStrobe_t;

  // arctan(2^-idx) as a fraction of a turn, scaled by 2^frac and rounded.
  // Base values are in units of 2^-32 turn.
  function automatic longint atanTurn(input int idx, input int frac);
    longint t;
    case (idx)
      0:  t = 64'h20000000;
      1:  t = 64'h12E4051D;
      2:  t = 64'h09FB385B;
      3:  t = 64'h051111D4;
      4:  t = 64'h028B0D43;
      5:  t = 64'h0145D7E1;
      6:  t = 64'h00A2F61E;
      7:  t = 64'h00517C55;
      8:  t = 64'h0028BE53;
      9:  t = 64'h00145F2E;
      10: t = 64'h000A2F98;
      11: t = 64'h000517CC;
      12: t = 64'h00028BE6;
      13: t = 64'h000145F3;
      14: t = 64'h0000A2F9;
      15: t = 64'h0000517C;
      default: t = 64'd683565276 >>> idx; // 2^32/(2*pi) * 2^-idx
    endcase
    return (t + (64'sd1 <<< (31 - frac))) >>> (32 - frac);
  endfunction

endpackage

// File: rtl/cordic_pretreat.sv
module cordic_pretreat #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int XW     = 20,
  parameter int ZW     = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  input  logic [ANG_W-1:0]     inAngle,
  output logic signed [XW-1:0] xOut,
  output logic signed [XW-1:0] yOut,
  output logic signed [ZW-1:0] zOut
);
  import cordic_pkg::*;

  localparam int SCALE = XW - DATA_W - 2;   // guard bits below the sample LSB
  localparam int ZPAD  = ZW - ANG_W;        // extra angle precision

  angleRange_e range;
  logic signed [XW-1:0] reW, imW, xNext, yNext;
  logic [ZW-1:0] zNext;

  assign range = angleRange_e'(inAngle[ANG_W-1 -: 2]);
  assign reW   = XW'(inRe) <<< SCALE;
  assign imW   = XW'(inIm) <<< SCALE;
  // residual keeps only the position within the quarter turn
  assign zNext = ZW'({inAngle[ANG_W-3:0], {ZPAD{1'b0}}});

  always_comb begin
    case (range)
      RANGE_DIRECT: begin
        xNext = reW;
        yNext = imW;
      end
      RANGE_QUARTER: begin   // multiply by +j
        xNext = -imW;
        yNext = reW;
      end
      default: begin         // half turn: negate both
        xNext = -reW;
        yNext = -imW;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOut <= '0;
      yOut <= '0;
      zOut <= '0;
    end else if (en) begin
      xOut <= xNext;
      yOut <= yNext;
      zOut <= zNext;
    end
  end

  // R1: accepted angles stay out of the illegal top quarter
  p_angle_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    en |-> (inAngle[ANG_W-1 -: 2] != 2'b11));

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int XW  = 20,
  parameter int ZW  = 22,
  parameter int IDX = 0,
  parameter logic [ZW-1:0] ANGLE = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic signed [XW-1:0] xIn,
  input  logic signed [XW-1:0] yIn,
  input  logic signed [ZW-1:0] zIn,
  output logic signed [XW-1:0] xOut,
  output logic signed [XW-1:0] yOut,
  output logic signed [ZW-1:0] zOut
);
  logic signed [XW-1:0] xSh, ySh;
  logic ccw;

  assign xSh = xIn >>> IDX;
  assign ySh = yIn >>> IDX;
  assign ccw = !zIn[ZW-1];  // turn toward zero residual

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOut <= '0;
      yOut <= '0;
      zOut <= '0;
    end else if (en) begin
      if (ccw) begin
        xOut <= xIn - ySh;
        yOut <= yIn + xSh;
        zOut <= zIn - ANGLE;
      end else begin
        xOut <= xIn + ySh;
        yOut <= yIn - xSh;
        zOut <= zIn + ANGLE;
      end
    end
  end

endmodule

// File: rtl/cordic_gain_comp.sv
module cordic_gain_comp #(
  parameter int DATA_W = 16,
  parameter int XW     = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     en,
  input  logic signed [XW-1:0]     xIn,
  input  logic signed [XW-1:0]     yIn,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  localparam int SCALE = XW - DATA_W - 2;
  localparam int KSH   = 16;                 // gain constant 39797 / 2^16
  localparam int SH    = KSH + SCALE;
  localparam int PW    = XW + KSH + 1;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  // shift-add multiply by 0.60725, round, clamp
  function automatic logic signed [DATA_W-1:0] scaleSat(input logic signed [XW-1:0] v);
    logic signed [PW-1:0] w, p, r;
    w = PW'(v);
    p = (w <<< 15) + (w <<< 13) - (w <<< 10) - (w <<< 7) - (w <<< 3) - (w <<< 2) + w;
    r = (p + RND) >>> SH;
    if (r > MAXV)      r = MAXV;
    else if (r < MINV) r = MINV;
    return r[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRe <= '0;
      outIm <= '0;
    end else if (en) begin
      outRe <= scaleSat(xIn);
      outIm <= scaleSat(yIn);
    end
  end

  // R9: outputs move only when a finished sample is loaded
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(outRe) && $stable(outIm)));

endmodule

// File: rtl/cordic_datapath.sv
module cordic_datapath #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int ITER   = 16,
  parameter int GUARD  = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cordic_pkg::cordicStrobe_t  strobe,
  input  logic [ITER-1:0]            stageLoad,
  input  logic signed [DATA_W-1:0]   inRe,
  input  logic signed [DATA_W-1:0]   inIm,
  input  logic [ANG_W-1:0]           inAngle,
  output logic signed [DATA_W-1:0]   outRe,
  output logic signed [DATA_W-1:0]   outIm
);
  localparam int XW = DATA_W + 2 + GUARD;   // 2 bits of growth plus guard
  localparam int ZW = ANG_W + GUARD + 4;    // finer residual angle
  localparam int RES_BOUND = int'(cordic_pkg::atanTurn(ITER - 1, ZW)) + ITER + 2;

  logic signed [XW-1:0] xs [0:ITER];
  logic signed [XW-1:0] ys [0:ITER];
  logic signed [ZW-1:0] zs [0:ITER];

  cordic_pretreat #(.DATA_W(DATA_W), .ANG_W(ANG_W), .XW(XW), .ZW(ZW)) u_pre (
    .clk(clk), .rstN(rstN), .en(strobe.loadPre),
    .inRe(inRe), .inIm(inIm), .inAngle(inAngle),
    .xOut(xs[0]), .yOut(ys[0]), .zOut(zs[0])
  );

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam logic [ZW-1:0] AI = ZW'(cordic_pkg::atanTurn(i, ZW));
    cordic_stage #(.XW(XW), .ZW(ZW), .IDX(i), .ANGLE(AI)) u_stage (
      .clk(clk), .rstN(rstN), .en(stageLoad[i]),
      .xIn(xs[i]), .yIn(ys[i]), .zIn(zs[i]),
      .xOut(xs[i+1]), .yOut(ys[i+1]), .zOut(zs[i+1])
    );
  end

  cordic_gain_comp #(.DATA_W(DATA_W), .XW(XW)) u_comp (
    .clk(clk), .rstN(rstN), .en(strobe.loadOut),
    .xIn(xs[ITER]), .yIn(ys[ITER]),
    .outRe(outRe), .outIm(outIm)
  );

  // R7: the micro-rotations converged on the folded angle
  p_residual_small_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |-> ((zs[ITER] <= RES_BOUND) && (zs[ITER] >= -RES_BOUND)));

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output cordic_pkg::cordicStrobe_t strobe,
  output logic [ITER-1:0]           stageLoad,
  output logic                      outValid
);
  localparam int LAT = ITER + 2;
  localparam int CW  = $clog2(LAT + 2);

  logic [ITER:0] validPipe;
  logic [CW-1:0] sinceIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      outValid  <= 1'b0;
    end else begin
      validPipe <= {validPipe[ITER-1:0], inValid};
      outValid  <= validPipe[ITER];
    end
  end

  assign strobe.loadPre = inValid;
  assign strobe.loadOut = validPipe[ITER];
  assign stageLoad      = validPipe[ITER-1:0];

  // cycles since the last accepted sample, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           sinceIn <= CW'(LAT + 1);
    else if (inValid)                    sinceIn <= CW'(1);
    else if (sinceIn != CW'(LAT + 1))    sinceIn <= sinceIn + CW'(1);
  end

  // R6: a valid output needs an input accepted within the pipeline depth
  p_out_has_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((sinceIn != '0) && (sinceIn <= CW'(LAT))));

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16,
  parameter int ITER   = 16,
  parameter int GUARD  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inRe,
  input  logic signed [DATA_W-1:0] inIm,
  input  logic [ANG_W-1:0]         inAngle,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outRe,
  output logic signed [DATA_W-1:0] outIm
);
  cordic_pkg::cordicStrobe_t strobe;
  logic [ITER-1:0] stageLoad;

  cordic_ctrl #(.ITER(ITER)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .stageLoad(stageLoad), .outValid(outValid)
  );

  cordic_datapath #(.DATA_W(DATA_W), .ANG_W(ANG_W), .ITER(ITER), .GUARD(GUARD)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stageLoad(stageLoad),
    .inRe(inRe), .inIm(inIm), .inAngle(inAngle),
    .outRe(outRe), .outIm(outIm)
  );

endmodule

// File: tb/sim_cordic_rotator.sv
module sim_cordic_rotator;
  localparam int LAT  = 18;
  localparam int TOL  = 5;
  localparam int NMAX = 4096;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rstN, inValid;
  logic signed [15:0] inRe, inIm;
  logic [15:0] inAngle;
  logic outValid;
  logic signed [15:0] outRe, outIm;

  cordic_rotator u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .inAngle(inAngle), .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  int expRe [NMAX];
  int expIm [NMAX];
  int stampArr [NMAX];
  int angArr [NMAX];
  bit satArr [NMAX];
  int wrIdx = 0, rdIdx = 0, cycle = 0, checks = 0, fails = 0;
  int lastRe = 0, lastIm = 0;
  bit monOn = 0, done = 0;

  always @(posedge clk) cycle++;

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int aRe, input int aIm,
                       input int eRe, input int eIm);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual (%0d,%0d) expected (%0d,%0d)", req, aRe, aIm, eRe, eIm);
    end
  endtask

  task automatic clampRound(input real v, output int r, inout bit sat);
    if (v > 32767.0)       begin r = 32767;  sat = 1'b1; end
    else if (v < -32768.0) begin r = -32768; sat = 1'b1; end
    else r = int'(v);
  endtask

  task automatic sendOne(input int re, input int im, input int ang);
    real th, xr, yr;
    int eR, eI;
    bit s;
    @(negedge clk);
    inValid = 1'b1; inRe = 16'(re); inIm = 16'(im); inAngle = 16'(ang);
    th = TWO_PI * ang / 65536.0;
    xr = re * $cos(th) - im * $sin(th);
    yr = re * $sin(th) + im * $cos(th);
    s = 1'b0;
    clampRound(xr, eR, s);
    clampRound(yr, eI, s);
    expRe[wrIdx] = eR; expIm[wrIdx] = eI; satArr[wrIdx] = s;
    angArr[wrIdx] = ang; stampArr[wrIdx] = cycle;
    wrIdx++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        if (rdIdx >= wrIdx) begin
          check(1'b0, "R6 extra output", outRe, outIm, 0, 0);
        end else begin
          string tag;
          case (angArr[rdIdx] >> 14)
            0: tag = "R1 R7 R2";
            1: tag = "R1 R7 R3";
            default: tag = "R1 R7 R4";
          endcase
          if (satArr[rdIdx]) tag = {tag, " R8"};
          check(absI(outRe - expRe[rdIdx]) <= TOL && absI(outIm - expIm[rdIdx]) <= TOL,
                tag, outRe, outIm, expRe[rdIdx], expIm[rdIdx]);
          check(cycle - stampArr[rdIdx] == LAT, "R5 latency",
                cycle - stampArr[rdIdx], 0, LAT, 0);
          rdIdx++;
        end
      end else begin
        check(outRe == lastRe && outIm == lastIm, "R9 hold", outRe, outIm, lastRe, lastIm);
      end
      lastRe = outRe;
      lastIm = outIm;
    end
  end

  int vr [6] = '{20000, 0, 12345, -32768, 32767, -32768};
  int vi [6] = '{0, -15000, -23456, 0, 32767, -32768};
  int edges [9] = '{0, 1, 16383, 16384, 16385, 32767, 32768, 32769, 49151};

  initial begin
    rstN = 1'b0; inValid = 1'b0; inRe = '0; inIm = '0; inAngle = '0;
    repeat (3) begin
      @(negedge clk);
      check(outValid == 1'b0 && outRe == 0 && outIm == 0, "R10 in reset",
            outRe, outIm, 0, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && outRe == 0 && outIm == 0, "R10 after reset",
          outRe, outIm, 0, 0);
    monOn = 1'b1;

    for (int v = 0; v < 6; v++) begin
      for (int a = 0; a < 49152; a += 97) begin
        sendOne(vr[v], vi[v], a);
        if (((a / 97) % 7) == 3) idle(1);   // R6 bubbles
      end
      for (int e = 0; e < 9; e++) sendOne(vr[v], vi[v], edges[e]);   // R3 R4 seams
      idle(2);
    end
    // saturating diagonals at an eighth of a turn: R8
    sendOne(32767, 32767, 8192);
    sendOne(-32768, -32768, 8192);
    idle(LAT + 5);
    check(rdIdx == wrIdx, "R6 count", rdIdx, 0, wrIdx, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual (%0d,0) expected (%0d,0)", rdIdx, wrIdx);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule